// File: doc/BRIEF.md
# Segmented Butterfly Match-Line Evaluator

This block decides whether one stored ternary entry matches a search word. The stored entry is a data word and a per-bit don't-care mask; a cell agrees with the search bit when its mask bit is set or when the data bit equals the search bit. The word is cut into equal segments of contiguous cells. Segment `k` covers bits `k*SEG_CELLS` up to `k*SEG_CELLS+SEG_CELLS-1`. The segments are grouped into stages.

A segment in the first stage is always evaluated. A segment in a later stage is evaluated only when every segment that feeds it from the previous stage was itself evaluated and agreed. Because the feeds cross between parallel branches, one early disagreement switches off segments in several branches at once. The evaluated-segment vector exposes this pruning so that a power model can count active segments.

The default form has 40 cells in eight 5-cell segments over three stages:
- Stage 1 holds segments 0 and 1.
- Stage 2 holds segments 2, 3 and 4.
- Stage 3 holds segments 5, 6 and 7.
- Each segment in stages 2 and 3 is fed by all segments of the stage before it.

With `WIDTH=144, SEG_CELLS=6` the block builds the wide form instead. That form has four lanes over six stages, and segment `k` lies in stage `k/4`, lane `k%4`. A segment in lane `l` is fed by lanes `l` and `(l+1)%4` of the previous stage.

The evaluation is combinational, and both outputs are registered. The outputs therefore show the result for the inputs present at the previous rising clock edge.

Top module: `seg_match_line`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `match_o` is 0 and `eval_o` is all zeros, whatever the inputs are.
- R2: A cell agrees when its `dc_i` bit is 1, whatever the data and search bits are. When its `dc_i` bit is 0, the cell agrees only if the `data_i` bit equals the `key_i` bit.
- R3: Segment `k` is made of bits `k*SEG_CELLS` to `k*SEG_CELLS+SEG_CELLS-1`. A difference at bit 4 therefore belongs to segment 0 in the default form, and a difference at bit 5 belongs to segment 1.
- R4: The first-stage bits of `eval_o` are always 1 after reset. In the default form these are bits 1:0.
- R5: In the default form, `eval_o[4:2]` are all 1 when segments 0 and 1 both agree, and are all 0 otherwise.
- R6: In the default form, `eval_o[7:5]` are all 1 when segments 2, 3 and 4 were all evaluated and all agree, and are all 0 otherwise.
- R7: `match_o` is 1 exactly when every last-stage segment was evaluated and agrees. This holds exactly when every cell of the word agrees. When `match_o` is 1, every bit of `eval_o` is 1.
- R8: `match_o` and `eval_o` change only at a rising clock edge. They show the result for the inputs sampled at that edge.
- R9: In the wide form (`WIDTH=144`, `SEG_CELLS=6`), a segment in stage `s>0`, lane `l` is evaluated only when the segments in lanes `l` and `(l+1)%4` of stage `s-1` were both evaluated and both agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both outputs update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_i | input | WIDTH | Search word |
| data_i | input | WIDTH | Stored data bits of the entry |
| dc_i | input | WIDTH | Stored don't-care mask; 1 means the cell agrees with any search bit |
| match_o | output | 1 | Registered whole-entry match |
| eval_o | output | WIDTH/SEG_CELLS | Registered flags, one per segment, set for each segment that was evaluated |

## Verification
The properties assume that the three data inputs are steady and defined at each rising edge. They also assume that the first edge after reset release carries real inputs. The stimulus changes the inputs only on the falling edge, and it holds reset until defined values are in place. The stimulus places disagreements deliberately in the first, middle and last stages and at segment boundaries. It hides some disagreements under don't-care bits and leaves others exposed. Random words with zero, one or two flipped bits then fill in the pruning patterns. A second instance in the wide form receives the same words, so that its lane-crossing feeds are exercised under the same pruning cases.

// File: rtl/ml_pkg.sv
package ml_pkg;

    localparam int ML_MAX_SEG = 64;
    localparam int ML_LANES   = 4;

    // True for the eight-segment form with stages of 2, 3 and 3 segments.
    function automatic bit ml_triad(input int nseg);
        return nseg == 8;
    endfunction

    function automatic int ml_stage_of(input int nseg, input int k);
        if (ml_triad(nseg)) begin
            if (k < 2) return 0;
            else if (k < 5) return 1;
            else return 2;
        end
        return k / ML_LANES;
    endfunction

    function automatic int ml_first_count(input int nseg);
        return ml_triad(nseg) ? 2 : ML_LANES;
    endfunction

    // Segments of the previous stage whose agreement enables segment k.
    function automatic logic [ML_MAX_SEG-1:0] ml_feed_mask(input int nseg, input int k);
        logic [ML_MAX_SEG-1:0] m;
        int s;
        int l;
        m = '0;
        s = ml_stage_of(nseg, k);
        if (s != 0) begin
            if (ml_triad(nseg)) begin
                for (int j = 0; j < nseg; j++)
                    if (ml_stage_of(nseg, j) == s - 1) m[j] = 1'b1;
            end else begin
                l = k % ML_LANES;
                m[(s-1)*ML_LANES + l] = 1'b1;
                m[(s-1)*ML_LANES + ((l+1) % ML_LANES)] = 1'b1;
            end
        end
        return m;
    endfunction

    function automatic logic [ML_MAX_SEG-1:0] ml_last_mask(input int nseg);
        logic [ML_MAX_SEG-1:0] m;
        m = '0;
        for (int j = 0; j < nseg; j++)
            if (ml_stage_of(nseg, j) == ml_stage_of(nseg, nseg-1)) m[j] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ml_seg_cmp.sv
module ml_seg_cmp #(
    parameter int CELLS = 5
) (
    input  logic [CELLS-1:0] key_i,
    input  logic [CELLS-1:0] data_i,
    input  logic [CELLS-1:0] dc_i,
    output logic             hit_o
);
    // A cell agrees when masked or when data equals key.
    logic [CELLS-1:0] cell_ok;

    always_comb begin
        cell_ok = (key_i ~^ data_i) | dc_i;
        hit_o   = &cell_ok;
    end
endmodule

// File: rtl/ml_chain.sv
module ml_chain
    import ml_pkg::*;
#(
    parameter int NSEG = 8
) (
    input  logic [NSEG-1:0] seg_hit_i,
    output logic [NSEG-1:0] seg_en_o,
    output logic            match_o
);
    localparam logic [ML_MAX_SEG-1:0] LAST_MASK = ml_last_mask(NSEG);

    logic [NSEG-1:0] ok_c;
    logic            tail_ok;

    // Segments are visited in ascending order, which is also stage order,
    // so every feed has been resolved before it is used.
    always_comb begin
        logic [ML_MAX_SEG-1:0] fm;
        logic                  en;
        ok_c     = '0;
        seg_en_o = '0;
        for (int k = 0; k < NSEG; k++) begin
            fm = ml_feed_mask(NSEG, k);
            en = 1'b1;
            for (int j = 0; j < NSEG; j++)
                if (fm[j] && !ok_c[j]) en = 1'b0;
            seg_en_o[k] = en;
            ok_c[k]     = en & seg_hit_i[k];
        end
    end

    always_comb begin
        tail_ok = 1'b1;
        for (int k = 0; k < NSEG; k++)
            if (LAST_MASK[k] && !ok_c[k]) tail_ok = 1'b0;
        match_o = tail_ok;
    end
endmodule

// File: rtl/seg_match_line.sv
module seg_match_line
    import ml_pkg::*;
#(
    parameter  int WIDTH     = 40,
    parameter  int SEG_CELLS = 5,
    localparam int NSEG      = WIDTH / SEG_CELLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] key_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic [WIDTH-1:0] dc_i,
    output logic             match_o,
    output logic [NSEG-1:0]  eval_o
);
    logic [NSEG-1:0] seg_hit;
    logic [NSEG-1:0] seg_en;
    logic            chain_match;

    generate
        for (genvar g = 0; g < NSEG; g++) begin : g_seg
            ml_seg_cmp #(.CELLS(SEG_CELLS)) u_cmp (
                .key_i  (key_i [g*SEG_CELLS +: SEG_CELLS]),
                .data_i (data_i[g*SEG_CELLS +: SEG_CELLS]),
                .dc_i   (dc_i  [g*SEG_CELLS +: SEG_CELLS]),
                .hit_o  (seg_hit[g])
            );
        end
    endgenerate

    ml_chain #(.NSEG(NSEG)) u_chain (
        .seg_hit_i (seg_hit),
        .seg_en_o  (seg_en),
        .match_o   (chain_match)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_o <= 1'b0;
            eval_o  <= '0;
        end else begin
            match_o <= chain_match;
            eval_o  <= seg_en;
        end
    end
endmodule

// File: rtl/seg_match_line_chk.sv
module seg_match_line_chk
    import ml_pkg::*;
#(
    parameter  int WIDTH     = 40,
    parameter  int SEG_CELLS = 5,
    localparam int NSEG      = WIDTH / SEG_CELLS,
    localparam int FIRST     = ml_first_count(NSEG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] key_i,
    input logic [WIDTH-1:0] data_i,
    input logic [WIDTH-1:0] dc_i,
    input logic             match_o,
    input logic [NSEG-1:0]  eval_o
);
    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R4
    first_stage_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (&eval_o[FIRST-1:0]));

    // R7
    match_full_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (&eval_o));

    // R2
    match_ternary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (match_o == (&$past((key_i ~^ data_i) | dc_i))));

    generate
        if (ml_triad(NSEG)) begin : g_triad
            // R5
            mid_needs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (|eval_o[4:2]) |-> ((&eval_o[4:2]) && (&eval_o[1:0])));
            // R6
            tail_needs_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (|eval_o[7:5]) |-> ((&eval_o[7:5]) && (&eval_o[4:0])));
        end
    endgenerate
endmodule

bind seg_match_line seg_match_line_chk #(.WIDTH(WIDTH), .SEG_CELLS(SEG_CELLS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_i   (key_i),
    .data_i  (data_i),
    .dc_i    (dc_i),
    .match_o (match_o),
    .eval_o  (eval_o)
);

// File: tb/seg_match_line_tb.sv
module seg_match_line_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [143:0] key_w, data_w, dc_w;
    logic         m_n, m_w;
    logic [7:0]   ev_n;
    logic [23:0]  ev_w;
    logic [23:0]  exp_ev_n, exp_ev_w;
    logic         exp_m_n, exp_m_w;
    int           total = 0;
    int           bad = 0;
    string        phase = "R1";

    always #4 clk = ~clk;

    seg_match_line #(.WIDTH(40), .SEG_CELLS(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .key_i(key_w[39:0]), .data_i(data_w[39:0]),
        .dc_i(dc_w[39:0]), .match_o(m_n), .eval_o(ev_n));

    seg_match_line #(.WIDTH(144), .SEG_CELLS(6)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .key_i(key_w), .data_i(data_w),
        .dc_i(dc_w), .match_o(m_w), .eval_o(ev_w));

    // Behavioural reference: stage and feed relation taken from the requirements.
    function automatic void model(input int w, input int cells,
                                  input logic [143:0] k, input logic [143:0] d,
                                  input logic [143:0] m,
                                  output logic [23:0] ev, output logic mt);
        int  nseg;
        int  stg [24];
        bit  raw [24];
        bit  feeds;
        nseg = w / cells;
        ev = '0;
        for (int i = 0; i < nseg; i++) begin
            if (nseg == 8) stg[i] = (i < 2) ? 0 : ((i < 5) ? 1 : 2);
            else           stg[i] = i / 4;
            raw[i] = 1'b1;
            for (int c = 0; c < cells; c++) begin
                int b;
                b = i*cells + c;
                if (!m[b] && (k[b] != d[b])) raw[i] = 1'b0;
            end
        end
        for (int i = 0; i < nseg; i++) begin
            ev[i] = 1'b1;
            if (stg[i] > 0)
                for (int j = 0; j < nseg; j++) begin
                    if (nseg == 8) feeds = 1'b1;
                    else feeds = ((j % 4) == (i % 4)) || ((j % 4) == ((i + 1) % 4));
                    if (stg[j] == stg[i] - 1 && feeds && !(ev[j] && raw[j])) ev[i] = 1'b0;
                end
        end
        mt = 1'b1;
        for (int i = 0; i < nseg; i++)
            if (stg[i] == stg[nseg-1] && !(ev[i] && raw[i])) mt = 1'b0;
    endfunction

    task automatic chk(input string req, input logic [23:0] got, input logic [23:0] expv);
        total++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s (phase %s): actual=%h expected=%h", req, phase, got, expv);
        end
    endtask

    task automatic compare_all();
        chk("R4", {22'd0, ev_n[1:0]}, {22'd0, exp_ev_n[1:0]});
        chk("R5", {21'd0, ev_n[4:2]}, {21'd0, exp_ev_n[4:2]});
        chk("R6", {21'd0, ev_n[7:5]}, {21'd0, exp_ev_n[7:5]});
        chk("R7", {23'd0, m_n}, {23'd0, exp_m_n});
        chk("R9", ev_w, exp_ev_w);
        chk("R9", {23'd0, m_w}, {23'd0, exp_m_w});
    endtask

    // Compare at the falling edge, then drive the next word.
    task automatic cycle(input logic [143:0] k, input logic [143:0] d,
                         input logic [143:0] m, input string ph);
        @(negedge clk);
        compare_all();
        key_w = k; data_w = d; dc_w = m; phase = ph;
        model(40, 5, k, d, m, exp_ev_n, exp_m_n);
        model(144, 6, k, d, m, exp_ev_w, exp_m_w);
    endtask

    function automatic logic [143:0] rnd144();
        return {$urandom(), $urandom(), $urandom(), $urandom(), 16'($urandom())};
    endfunction

    function automatic logic [143:0] bit1(input int b);
        logic [143:0] v;
        v = '0;
        v[b] = 1'b1;
        return v;
    endfunction

    initial begin
        logic [143:0] k;
        k = rnd144();
        key_w = k; data_w = k; dc_w = '0;
        // R1: outputs held clear while reset is low, inputs matching
        repeat (3) @(negedge clk);
        chk("R1", {15'd0, m_n, ev_n}, 24'd0);
        chk("R1", {m_w, ev_w[22:0]}, 24'd0);
        rst_n = 1'b1;
        model(40, 5, key_w, data_w, dc_w, exp_ev_n, exp_m_n);
        model(144, 6, key_w, data_w, dc_w, exp_ev_w, exp_m_w);

        cycle(k, k, '0, "R7");
        cycle(k, k ^ bit1(0), '0, "R5");
        cycle(k, k ^ bit1(15), '0, "R6");
        cycle(k, k ^ bit1(39), '0, "R7");
        cycle(k, k ^ bit1(4), '0, "R3");
        cycle(k, k ^ bit1(5), '0, "R3");
        cycle(k, k ^ bit1(10), '0, "R3");
        cycle(k, k ^ bit1(7) ^ bit1(22), bit1(7) | bit1(22), "R2");
        cycle(k, k ^ bit1(7) ^ bit1(22), bit1(7), "R2");
        cycle(rnd144(), rnd144(), {144{1'b1}}, "R2");
        cycle(k, k ^ bit1(60), '0, "R9");
        cycle(k, k ^ bit1(100), '0, "R9");
        cycle(k, k ^ bit1(143), '0, "R9");
        cycle(k, k, '0, "R8");

        // R8: new inputs between edges leave the outputs untouched
        @(negedge clk);
        compare_all();
        key_w = k; data_w = k ^ bit1(0); dc_w = '0;
        #1;
        chk("R8", {15'd0, m_n, ev_n}, {15'd0, exp_m_n, exp_ev_n[7:0]});
        model(40, 5, key_w, data_w, dc_w, exp_ev_n, exp_m_n);
        model(144, 6, key_w, data_w, dc_w, exp_ev_w, exp_m_w);

        for (int n = 0; n < 400; n++) begin
            logic [143:0] kk, dd, mm;
            int flips;
            kk = rnd144();
            dd = kk;
            flips = $urandom_range(0, 2);
            for (int f = 0; f < flips; f++) dd[$urandom_range(0, 143)] ^= 1'b1;
            mm = ($urandom_range(0, 3) == 0) ? (rnd144() & rnd144()) : '0;
            cycle(kk, dd, mm, "R7");
        end
        cycle(k, k, '0, "R7");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule